// File: doc/BRIEF.md
# Self-Recovering Zero-Home Ring Sequencer

This block is a ring sequencer that steps through `NUM_STATES` states using only `NUM_STATES-1` flip-flops. The home state is the all-zero vector and every other state holds exactly one set bit. The first stage is loaded with the NOR of all state bits. As a result, an empty register always restarts from home. Any surplus set bits move toward the most significant end and drop off the last stage, so the ring falls back into its legal cycle with no dedicated error logic.

With the default of four states, the ring runs 000, 001, 010, 100 and then returns to 000. Two registered phase outputs are decoded from this sequence to form a two-phase, non-overlapping clock. Phase one is high in the first state after home. Phase two is high in the last state. A fault-mask input flips chosen bits of the value loaded at a clock edge, so upsets can be injected at the ports.

Top module: `zero_home_ring`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the all-zero home state and drives both phase outputs low. Reset takes priority over any fault mask.
- R2: With a zero fault mask and starting from home, the 4-state instance visits 000, 001, 010, 100 and then 000 again, one state per clock. `state` bit 0 is the first stage.
- R3: The first stage loads 1 when the current state is all zeros and loads 0 otherwise (with a zero fault mask).
- R4: Each stage above the first loads the previous value of the stage just below it. The value in the top stage is discarded.
- R5: With a zero fault mask, any state with several set bits reaches home within `NUM_STATES-1` clocks and then follows the legal cycle.
- R6: `phase1` is high exactly while `state` equals 001 (only bit 0 set). `phase2` is high exactly while `state` equals 100 (only the top bit set). Both are registered and change at the same edge as `state`.
- R7: `phase1` and `phase2` are never high together. A cycle with `phase1` high is never followed directly by a cycle with `phase2` high.
- R8: At each edge without reset, the loaded state is the normal next state XOR `fault_mask` (bit i of the mask inverts stage i). An all-zero mask leaves the sequence unchanged.
- R9: A 1-to-0 upset of the single set bit gives home, which is a legal state. The ring then continues with 001 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fault_mask | input | NUM_STATES-1 | Bits to invert in the value loaded at this edge |
| state | output | NUM_STATES-1 | Current ring state, bit 0 is the first stage |
| phase1 | output | 1 | First non-overlapping phase |
| phase2 | output | 1 | Second non-overlapping phase |

## Verification
The bench forces every one of the eight 3-bit codes into the ring through the fault mask and then lets the ring run free. This exposes designs that lock up, for example one without NOR feedback that stays stuck at 000, or one that recirculates the top bit and keeps extra 1s circling forever. Phase outputs are compared against the state in every cycle. A decode taken from the current state instead of the next state would lag by one clock, and a loose decode would raise a phase in illegal multi-bit codes. Silent 1-to-0 upsets and a reset asserted together with a non-zero mask are also applied, which catches masks that bypass reset.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // number of flip-flops needed for a zero-home ring of the given state count
  function automatic int unsigned ring_bits(input int unsigned states);
    return states - 1;
  endfunction

  // width of a counter able to hold values 0..states
  function automatic int unsigned run_count_bits(input int unsigned states);
    return $clog2(states + 1) + 1;
  endfunction
endpackage

// File: rtl/ring_feedback.sv
module ring_feedback #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] cur_state,
  output logic         feed_bit
);
  // NOR of all stages: an empty register injects a 1 into the first stage
  function automatic logic nor_all(input logic [W-1:0] v);
    return ~(|v);
  endfunction

  always_comb feed_bit = nor_all(cur_state);
endmodule

// File: rtl/ring_shift.sv
module ring_shift #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         feed_bit,
  input  logic [W-1:0] upset_mask,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_next
);
  logic [W-1:0] shifted;
  logic         rst_d_q;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb shifted[g] = feed_bit;
      end else begin : g_rest
        always_comb shifted[g] = state_q[g-1];
      end
      always_comb state_next[g] = rst ? 1'b0 : (shifted[g] ^ upset_mask[g]);
      always_ff @(posedge clk) state_q[g] <= state_next[g];
    end
  endgenerate

  always_ff @(posedge clk) rst_d_q <= rst;

  always @(posedge clk) begin
    if (rst_d_q) begin
      assert_reset_home_R1: assert (state_q == '0)
        else $error("state not home after reset");
    end
  end

  assert_shift_up_R4: assert property (@(posedge clk) disable iff (rst)
    (upset_mask == '0) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));
endmodule

// File: rtl/phase_decode.sv
module phase_decode #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] state_next,
  output logic         phase1_q,
  output logic         phase2_q
);
  function automatic logic only_bit(input logic [W-1:0] v, input int unsigned idx);
    logic [W-1:0] code;
    code      = '0;
    code[idx] = 1'b1;
    return v == code;
  endfunction

  // decode the value being loaded so the phases line up with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      phase1_q <= 1'b0;
      phase2_q <= 1'b0;
    end else begin
      phase1_q <= only_bit(state_next, 0);
      phase2_q <= only_bit(state_next, W - 1);
    end
  end
endmodule

// File: rtl/zero_home_ring.sv
module zero_home_ring
  import ring_pkg::*;
#(
  parameter int unsigned NUM_STATES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_STATES-2:0]     fault_mask,
  output logic [NUM_STATES-2:0]     state,
  output logic                      phase1,
  output logic                      phase2
);
  localparam int unsigned W  = ring_bits(NUM_STATES);
  localparam int unsigned CW = run_count_bits(NUM_STATES);
  localparam logic [W-1:0] FIRST_CODE = W'(1);
  localparam logic [W-1:0] LAST_CODE  = W'(1) << (W - 1);

  logic         feed_bit;
  logic [W-1:0] state_next;

  ring_feedback #(.W(W)) u_feedback (
    .cur_state (state),
    .feed_bit  (feed_bit)
  );

  ring_shift #(.W(W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .feed_bit   (feed_bit),
    .upset_mask (fault_mask),
    .state_q    (state),
    .state_next (state_next)
  );

  phase_decode #(.W(W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .state_next (state_next),
    .phase1_q   (phase1),
    .phase2_q   (phase2)
  );

  // consecutive non-home states loaded without an injected upset
  logic [CW-1:0] run_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || (fault_mask != '0)) run_cnt_q <= '0;
    else if (state_next != '0)     run_cnt_q <= run_cnt_q + 1'b1;
    else                           run_cnt_q <= '0;
  end

  assert_home_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (state == '0 && fault_mask == '0) |=> (state == FIRST_CODE));

  assert_flush_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run_cnt_q <= CW'(W));

  assert_phase_match_R6: assert property (@(posedge clk) disable iff (rst)
    (phase1 == (state == FIRST_CODE)) && (phase2 == (state == LAST_CODE)));

  assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(phase1 && phase2));

  assert_phase_gap_R7: assert property (@(posedge clk) disable iff (rst)
    phase1 |=> !phase2);
endmodule

// File: tb/tb_zero_home_ring.sv
module tb_zero_home_ring;
  localparam int NS   = 4;
  localparam int W    = NS - 1;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] fault_mask = '0;
  logic [W-1:0] state;
  logic         phase1, phase2;

  int errors = 0;
  int checks = 0;
  int expv   = 0;
  logic prev_p1 = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  zero_home_ring #(.NUM_STATES(NS)) dut (
    .clk(clk), .rst(rst), .fault_mask(fault_mask),
    .state(state), .phase1(phase1), .phase2(phase2)
  );

  function automatic int advance(input int s);
    return ((s << 1) & FULL) | ((s == 0) ? 1 : 0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock with given reset and mask; sample 1 ns after the edge
  task automatic tick(input string tag, input logic r, input int m);
    @(negedge clk);
    rst = r;
    fault_mask = W'(m);
    @(posedge clk);
    #1;
    expv = r ? 0 : (advance(expv) ^ m);
    check(tag, int'(state), expv);
    check("R6 phase1", int'(phase1), (expv == 1) ? 1 : 0);
    check("R6 phase2", int'(phase2), (expv == (1 << (W - 1))) ? 1 : 0);
    check("R7 overlap", int'(phase1 && phase2), 0);
    if (prev_p1) check("R7 gap", int'(phase2), 0);
    prev_p1 = phase1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick("R1 reset", 1'b1, 0);
    tick("R1 reset", 1'b1, 0);
    // R2/R3/R4: free run from home, two full laps
    for (int i = 0; i < 2 * NS; i++) tick("R2 sequence", 1'b0, 0);
    // R8/R5: force every code, then let it flush and rejoin the cycle
    for (int t = 0; t <= FULL; t++) begin
      tick("R1 reset", 1'b1, 0);
      tick("R8 mask load", 1'b0, 1 ^ t);
      for (int k = 0; k < W + NS; k++) tick("R5 flush", 1'b0, 0);
      checks++;
      if (!(state == 0 || state == 1 || state == 2 || state == 4)) begin
        errors++;
        $display("FAIL R5 legal: actual=%0d expected=one of 0,1,2,4", state);
      end
    end
    // R3/R4: bit-by-bit after extra ones (111 -> 110 -> 100 -> 000 -> 001)
    tick("R1 reset", 1'b1, 0);
    tick("R8 mask load", 1'b0, 6);
    for (int k = 0; k < 4; k++) tick("R4 shift out", 1'b0, 0);
    // R9: silent 1-to-0 upset of the set bit while at 010
    tick("R1 reset", 1'b1, 0);
    tick("R2 sequence", 1'b0, 0);
    tick("R2 sequence", 1'b0, 0);
    tick("R9 drop to home", 1'b0, 4);
    tick("R9 resume", 1'b0, 0);
    tick("R9 resume", 1'b0, 0);
    // R1: reset wins over a non-zero mask
    tick("R1 reset priority", 1'b1, FULL);
    tick("R3 restart", 1'b0, 0);
    // R8: mask on a running ring (001 -> next 010, mask 101 -> 111)
    tick("R8 mask run", 1'b0, 5);
    for (int k = 0; k < 5; k++) tick("R5 flush", 1'b0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule